// File: doc/BRIEF.md
# Windowed AIS Detector

This block watches a stream of recovered line bits and raises an alarm indication signal (AIS) flag when the line carries almost nothing but ones. It does not judge a continuous run of ones. It cuts the bit stream into fixed-length windows that follow one another with no overlap and no gap. It counts the zeros in each window and makes one decision when the window closes. One zero-count threshold declares the alarm and a higher one clears it, so the flag has hysteresis. The window length and both thresholds depend on whether the line is in E1 or T1 mode.

A bit is consumed only on a cycle where the strobe is high, so the block runs from a fast system clock at any bit rate. The flag is registered. It can move only on the clock edge that takes in the last bit of a window, which means that once it changes it holds for at least one full window. Changing the mode throws away the window in progress and starts a new one with the new length. The flag itself is left as it is.

Top module: `ais_window_detector`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, ais_o is 0. The first window starts with no bits and no zeros counted.
- R2: In E1 mode (mode_t1_i = 0) a window is 512 strobed bits. If ais_o is 0 and the closing window holds 2 or fewer zeros, ais_o becomes 1. With 3 zeros it stays 0.
- R3: In E1 mode, if ais_o is 1 and the closing window holds 3 or more zeros, ais_o becomes 0. With 2 or fewer zeros it stays 1.
- R4: In T1 mode (mode_t1_i = 1) a window is 4632 strobed bits. If ais_o is 0 and the closing window holds 4 or fewer zeros, ais_o becomes 1. With 5 zeros it stays 0.
- R5: In T1 mode, if ais_o is 1 and the closing window holds 5 or more zeros, ais_o becomes 0.
- R6: ais_o changes only on the clock edge that samples the strobe completing a window. The new value is visible from that edge onward, and it holds for at least one full window.
- R7: On a cycle where mode_t1_i differs from its value on the previous cycle, the current window restarts with zero bits and zero zeros. Any strobe on that cycle is discarded and ais_o is unchanged. Windows then use the new mode's length and thresholds.
- R8: A cycle with bit_vld_i low neither advances the window nor changes the zero count.
- R9: The zero count saturates at the active clear threshold. A window made entirely of zeros therefore clears the alarm; the count never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Strobe: bit_i carries a received bit this cycle |
| bit_i | input | 1 | Recovered bit value, 0 or 1 |
| mode_t1_i | input | 1 | Line mode: 0 = E1, 1 = T1 |
| ais_o | output | 1 | AIS flag, registered |

## Verification
The assertions take three things for granted:
- mode_t1_i and bit_vld_i are synchronous to clk_i.
- bit_i is only meaningful when the strobe is high.
- The mode is sampled into the block on every cycle, so a change is detected on the first cycle in which mode_t1_i differs from its last sampled value.

The stimulus drives all inputs on the falling edge, so every value is stable at the rising edge that samples it. The bench places zeros at known positions in each window and inserts idle cycles between strobes in one window. It switches the mode in the middle of a window, and a strobe arrives on the same cycle as the switch. This keeps the counting of windows, and the dropping of that strobe, under its control.

// File: rtl/ais_det_pkg.sv
package ais_det_pkg;
  typedef enum logic {
    LINE_E1 = 1'b0,
    LINE_T1 = 1'b1
  } line_mode_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ais_win_timer.sv
module ais_win_timer #(
  parameter int unsigned PW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          step_i,
  input  logic [PW-1:0] last_i,
  output logic          win_end_o,
  output logic [PW-1:0] pos_o
);
  logic [PW-1:0] pos_q;

  assign win_end_o = step_i && !restart_i && (pos_q == last_i);
  assign pos_o     = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pos_q <= '0;
    else if (restart_i)    pos_q <= '0;
    else if (step_i) begin
      if (pos_q == last_i) pos_q <= '0;
      else                 pos_q <= pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/ais_zero_cnt.sv
module ais_zero_cnt #(
  parameter int unsigned ZW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          step_i,
  input  logic          bit_i,
  input  logic          win_end_i,
  input  logic [ZW-1:0] sat_i,
  output logic [ZW-1:0] cnt_o,
  output logic [ZW-1:0] total_o
);
  logic [ZW-1:0] cnt_q;

  // count including the bit on the strobe, saturated
  always_comb begin
    if (!bit_i && (cnt_q < sat_i)) total_o = cnt_q + 1'b1;
    else                           total_o = cnt_q;
  end

  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step_i) begin
      if (win_end_i)    cnt_q <= '0;
      else              cnt_q <= total_o;
    end
  end
endmodule

// File: rtl/ais_decide.sv
module ais_decide #(
  parameter int unsigned ZW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          win_end_i,
  input  logic [ZW-1:0] total_i,
  input  logic [ZW-1:0] decl_max_i,
  input  logic [ZW-1:0] clr_min_i,
  output logic          ais_o
);
  logic ais_q;

  assign ais_o = ais_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ais_q <= 1'b0;
    else if (win_end_i) begin
      if (!ais_q && (total_i <= decl_max_i))     ais_q <= 1'b1;
      else if (ais_q && (total_i >= clr_min_i))  ais_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ais_window_detector.sv
module ais_window_detector #(
  parameter int unsigned E1_WIN      = 512,
  parameter int unsigned E1_DECL_MAX = 2,
  parameter int unsigned E1_CLR_MIN  = 3,
  parameter int unsigned T1_WIN      = 4632,
  parameter int unsigned T1_DECL_MAX = 4,
  parameter int unsigned T1_CLR_MIN  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic mode_t1_i,
  output logic ais_o
);
  import ais_det_pkg::*;

  localparam int unsigned MAX_WIN = max_u(E1_WIN, T1_WIN);
  localparam int unsigned MAX_CLR = max_u(E1_CLR_MIN, T1_CLR_MIN);
  localparam int unsigned PW      = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
  localparam int unsigned ZW      = $clog2(MAX_CLR + 1);

  localparam logic [PW-1:0] E1_LAST = PW'(E1_WIN - 1);
  localparam logic [PW-1:0] T1_LAST = PW'(T1_WIN - 1);
  localparam logic [ZW-1:0] E1_DECL = ZW'(E1_DECL_MAX);
  localparam logic [ZW-1:0] T1_DECL = ZW'(T1_DECL_MAX);
  localparam logic [ZW-1:0] E1_CLR  = ZW'(E1_CLR_MIN);
  localparam logic [ZW-1:0] T1_CLR  = ZW'(T1_CLR_MIN);

  line_mode_e    mode_q;
  line_mode_e    mode_in;
  logic          restart;
  logic          win_end;
  logic [PW-1:0] pos;
  logic [PW-1:0] win_last;
  logic [ZW-1:0] zcnt;
  logic [ZW-1:0] total;
  logic [ZW-1:0] decl_max;
  logic [ZW-1:0] clr_min;

  assign mode_in = line_mode_e'(mode_t1_i);
  assign restart = (mode_in != mode_q);

  // window settings follow the mode of the running window
  always_comb begin
    if (mode_q == LINE_T1) begin
      win_last = T1_LAST;
      decl_max = T1_DECL;
      clr_min  = T1_CLR;
    end else begin
      win_last = E1_LAST;
      decl_max = E1_DECL;
      clr_min  = E1_CLR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= LINE_E1;
    else         mode_q <= mode_in;
  end

  ais_win_timer #(.PW(PW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .step_i    (bit_vld_i),
    .last_i    (win_last),
    .win_end_o (win_end),
    .pos_o     (pos)
  );

  ais_zero_cnt #(.ZW(ZW)) u_zeros (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .step_i    (bit_vld_i),
    .bit_i     (bit_i),
    .win_end_i (win_end),
    .sat_i     (clr_min),
    .cnt_o     (zcnt),
    .total_o   (total)
  );

  ais_decide #(.ZW(ZW)) u_decide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_end_i  (win_end),
    .total_i    (total),
    .decl_max_i (decl_max),
    .clr_min_i  (clr_min),
    .ais_o      (ais_o)
  );
endmodule

// File: rtl/ais_det_checker.sv
module ais_det_checker #(
  parameter int unsigned PW = 13,
  parameter int unsigned ZW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_vld_i,
  input logic          ais_o,
  input logic          restart,
  input logic          win_end,
  input logic [PW-1:0] pos,
  input logic [PW-1:0] win_last,
  input logic [ZW-1:0] zcnt,
  input logic [ZW-1:0] total,
  input logic [ZW-1:0] decl_max,
  input logic [ZW-1:0] clr_min
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |=> !ais_o); // R1

  AST_DECLARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end && !ais_o && (total <= decl_max)) |=> ais_o); // R2

  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end && ais_o && (total >= clr_min)) |=> !ais_o); // R3

  AST_POS_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos <= win_last); // R4

  AST_MOVE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ais_o != $past(ais_o)) |-> ($past(win_end) && (pos == '0) && (zcnt == '0))); // R6

  AST_RESTART_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> ((pos == '0) && (zcnt == '0))); // R7

  AST_RESTART_KEEPS_AIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> $stable(ais_o)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_vld_i && !restart) |=> ($stable(pos) && $stable(zcnt))); // R8

  AST_ZERO_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zcnt <= clr_min); // R9
endmodule

bind ais_window_detector ais_det_checker #(.PW(PW), .ZW(ZW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_vld_i (bit_vld_i),
  .ais_o     (ais_o),
  .restart   (restart),
  .win_end   (win_end),
  .pos       (pos),
  .win_last  (win_last),
  .zcnt      (zcnt),
  .total     (total),
  .decl_max  (decl_max),
  .clr_min   (clr_min)
);

// File: tb/tb_ais_window_detector.sv
`timescale 1ns/1ps
module tb_ais_window_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_v = 1'b1;
  logic mode_t1 = 1'b0;
  logic ais;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference
  int m_pos = 0;
  int m_zeros = 0;
  bit m_ais = 1'b0;
  bit m_mode = 1'b0;

  always #10 clk = ~clk;

  ais_window_detector dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bit_vld_i (bit_vld),
    .bit_i     (bit_v),
    .mode_t1_i (mode_t1),
    .ais_o     (ais)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_zeros = 0; m_ais = 1'b0; m_mode = 1'b0;
    end else if (mode_t1 != m_mode) begin
      m_mode = mode_t1; m_pos = 0; m_zeros = 0;
    end else if (bit_vld) begin
      int wl;
      int z;
      wl = m_mode ? 4632 : 512;
      z  = m_zeros + (bit_v ? 0 : 1);
      if (m_pos == wl - 1) begin
        if (!m_ais && z <= (m_mode ? 4 : 2)) m_ais = 1'b1;
        else if (m_ais && z >= (m_mode ? 5 : 3)) m_ais = 1'b0;
        m_pos = 0; m_zeros = 0;
      end else begin
        m_pos = m_pos + 1; m_zeros = z;
      end
    end
  end

  // every-cycle comparison against the model (R6 timing of updates)
  always @(negedge clk) begin
    checks++;
    if (ais !== m_ais) begin
      errors++;
      $display("FAIL R6 model t=%0t actual=%b expected=%b", $time, ais, m_ais);
    end
  end

  task automatic chk(input logic exp, input string req);
    checks++;
    if (ais !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, ais, exp);
    end
  endtask

  // n strobed bits, the first nz of them zero; optional idle cycle after each
  task automatic send_bits(input int n, input int nz, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b1;
      bit_v   = (i < nz) ? 1'b0 : 1'b1;
      if (gaps) begin
        @(negedge clk);
        bit_vld = 1'b0;
      end
    end
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic switch_mode(input logic m, input logic b);
    @(negedge clk);
    mode_t1 = m;
    bit_vld = 1'b1;
    bit_v   = b;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, "R1 after reset");

    send_bits(512, 2, 1'b0);  chk(1'b1, "R2 E1 two zeros declares");
    send_bits(512, 2, 1'b0);  chk(1'b1, "R3 E1 two zeros keeps alarm");
    send_bits(512, 3, 1'b0);  chk(1'b0, "R3 E1 three zeros clears");
    send_bits(512, 3, 1'b0);  chk(1'b0, "R2 E1 three zeros no declare");

    send_bits(511, 0, 1'b0);  chk(1'b0, "R6 no change before window end");
    send_bits(1, 0, 1'b0);    chk(1'b1, "R6 change on closing strobe");

    send_bits(300, 0, 1'b1);  chk(1'b1, "R8 idle cycles do not close window");
    send_bits(212, 212, 1'b1); chk(1'b0, "R9 all-zero window clears");

    send_bits(300, 0, 1'b0);
    switch_mode(1'b1, 1'b1);  chk(1'b0, "R7 switch keeps flag");
    send_bits(4631, 4, 1'b0); chk(1'b0, "R7 window restarted at switch");
    send_bits(1, 0, 1'b0);    chk(1'b1, "R4 T1 four zeros declares");
    send_bits(4632, 5, 1'b0); chk(1'b0, "R5 T1 five zeros clears");
    send_bits(4632, 5, 1'b0); chk(1'b0, "R4 T1 five zeros no declare");
    send_bits(4632, 4, 1'b0); chk(1'b1, "R4 T1 four zeros declares again");

    send_bits(100, 0, 1'b0);
    switch_mode(1'b0, 1'b0);  chk(1'b1, "R7 switch keeps alarm");
    send_bits(511, 3, 1'b0);  chk(1'b1, "R7 E1 window restarted");
    send_bits(1, 0, 1'b0);    chk(1'b0, "R3 E1 clear after switch");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule